// File: doc/BRIEF.md
# Banked Level Interrupt Collector

This block gathers level-sensitive interrupt lines into one or two banks of thirty-two sources each. It raises a single registered request towards a parent controller and, optionally, reports the index of the highest-numbered source that is currently pending. Software reaches each bank through a small register window: the live line levels, the mask, a pending view that is the lines gated by the mask, and two write-only strobes that set or clear individual mask bits without a read-modify-write.

Source `n` of bank `b` has global index `b*32+n`. Bank `b` occupies byte addresses from `b*0x20` upwards. Inside a bank, the word offsets are 0x00 line levels, 0x04 mask, 0x08 mask-set strobe, 0x0C mask-clear strobe and 0x10 pending. A mask bit of 1 blocks its source. Reads return data one clock after the read strobe.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask bit reads 1 (mask offset 0x04 reads 0xFFFFFFFF in each bank), and `irq_out` and `top_valid` are 0.
- R2: Writing the mask-set offset (0x08) sets each mask bit whose data bit is 1 and leaves bits written 0 unchanged; all ones masks the whole bank.
- R3: Writing the mask-clear offset (0x0C) clears each mask bit whose data bit is 1 and leaves bits written 0 unchanged.
- R4: The line-level offset (0x00) reads the present level of each input, with no latching: a line that drops reads 0 again.
- R5: The pending offset (0x10) reads line level AND NOT mask.
- R6: `irq_out` is the OR of all pending bits of all banks, registered: it changes on the first rising edge after the pending set changes.
- R7: Bank `b` decodes at byte base `b*0x20`, and its source `n` is reported as global index `b*32+n`.
- R8: Writes to the line-level, mask and pending offsets change nothing.
- R9: Offsets 0x14, 0x18, 0x1C, addresses with nonzero low two bits, and banks beyond the configured count read 0 and ignore writes; the set and clear strobes read 0.
- R10: `top_valid` equals the registered OR of pending bits and `top_idx` gives the highest global index that was pending, both updated on the same edge as `irq_out`.
- R11: `bus_rdata` holds the addressed word on the edge after `bus_re` is sampled high and is 0 after an edge where `bus_re` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*32 | Level interrupt lines, bit `b*32+n` is source `n` of bank `b` |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered summary request to the parent |
| top_valid | output | 1 | Index output is meaningful |
| top_idx | output | $clog2(NUM_BANKS*32) | Highest pending global index |

## Verification
A corrupted mask bit is visible at the ports in two ways: the mask readback differs one cycle after the read strobe, and the pending word and `irq_out` disagree with the line levels by the next edge. A decode fault that lets a write reach the wrong bank or offset shows up as a mask that moved when a later mask read expects it unchanged. A wrong priority or bank offset in the encoder shows on `top_idx` on the same edge that raises `irq_out`, so each stimulus vector checks the index together with the pending words.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int LINES_PER_BANK = 32;
   localparam int BANK_SHIFT     = 5;   // 0x20 byte stride per bank
   localparam int WORD_W         = 32;

   // word offsets inside a bank (byte offset / 4)
   localparam logic [2:0] WOFF_LEVEL = 3'd0;
   localparam logic [2:0] WOFF_MASK  = 3'd1;
   localparam logic [2:0] WOFF_SET   = 3'd2;
   localparam logic [2:0] WOFF_CLR   = 3'd3;
   localparam logic [2:0] WOFF_PEND  = 3'd4;

   function automatic logic [WORD_W-1:0] bank_word(
      input logic [2:0]        woff,
      input logic [WORD_W-1:0] level,
      input logic [WORD_W-1:0] mask,
      input logic [WORD_W-1:0] pend);
      logic [WORD_W-1:0] r;
      case (woff)
         WOFF_LEVEL: r = level;
         WOFF_MASK:  r = mask;
         WOFF_PEND:  r = pend;
         default:    r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int LINES = LINES_PER_BANK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [LINES-1:0] wdata,
   output logic [LINES-1:0] mask_o,
   output logic [LINES-1:0] pend_o
);

   logic [LINES-1:0] mask_q;
   logic [LINES-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (set_we) mask_d = mask_d | wdata;
      if (clr_we) mask_d = mask_d & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '1;
      else        mask_q <= mask_d;
   end

   assign mask_o = mask_q;
   assign pend_o = lines & ~mask_q;

   p_set_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask_q & $past(wdata)) == $past(wdata)));

   p_clr_unmasks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((mask_q & $past(wdata)) == '0));

   p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_q));

endmodule

// File: rtl/intc_summary.sv
module intc_summary #(
   parameter int SRC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] pend,
   output logic             req_o
);

   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= |pend;
   end

   assign req_o = req_q;

   p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |=> req_o);

   p_req_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !req_o);

endmodule

// File: rtl/intc_top_enc.sv
module intc_top_enc #(
   parameter int SRC_W     = 64,
   parameter int IDX_W     = 6,
   parameter bit HAS_INDEX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] pend,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);

   generate
      if (HAS_INDEX) begin : g_enc
         logic [IDX_W-1:0] idx_c;
         logic             hit_c;
         logic [IDX_W-1:0] idx_q;
         logic             valid_q;

         always_comb begin
            idx_c = '0;
            hit_c = 1'b0;
            for (int i = 0; i < SRC_W; i++) begin
               if (pend[i]) begin
                  idx_c = IDX_W'(i);
                  hit_c = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q   <= '0;
               valid_q <= 1'b0;
            end else begin
               idx_q   <= idx_c;
               valid_q <= hit_c;
            end
         end

         assign valid_o = valid_q;
         assign idx_o   = idx_q;

         p_idx_highest_r10: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (($past(pend) >> idx_o) == SRC_W'(1)));

         p_valid_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pend == '0) |=> !valid_o);
      end else begin : g_no_enc
         assign valid_o = 1'b0;
         assign idx_o   = '0;
      end
   endgenerate

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
   import intc_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 6,
   parameter bit HAS_INDEX = 1'b1,
   localparam int SRC_W    = NUM_BANKS * LINES_PER_BANK,
   localparam int IDX_W    = $clog2(SRC_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_W-1:0]   irq_src,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [WORD_W-1:0]  bus_wdata,
   input  logic               bus_we,
   input  logic               bus_re,
   output logic [WORD_W-1:0]  bus_rdata,
   output logic               irq_out,
   output logic               top_valid,
   output logic [IDX_W-1:0]   top_idx
);

   localparam int BSEL_W = ADDR_W - BANK_SHIFT;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
         $error("lvl_intc: NUM_BANKS must be 1 or 2");
      end
      if (ADDR_W < BANK_SHIFT + 1) begin : g_bad_addr
         $error("lvl_intc: ADDR_W too small for bank select");
      end
   endgenerate

   logic              aligned;
   logic [2:0]        woff;
   logic [BSEL_W-1:0] bsel;

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign woff    = bus_addr[4:2];
   assign bsel    = bus_addr[ADDR_W-1:BANK_SHIFT];

   logic [SRC_W-1:0]  pend_all;
   logic [WORD_W-1:0] rword [NUM_BANKS];

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic              hit;
         logic              set_we;
         logic              clr_we;
         logic [WORD_W-1:0] mask;
         logic [WORD_W-1:0] pend;
         logic [WORD_W-1:0] lvl;

         assign lvl    = irq_src[b*LINES_PER_BANK +: LINES_PER_BANK];
         assign hit    = aligned && (bsel == BSEL_W'(b));
         assign set_we = bus_we && hit && (woff == WOFF_SET);
         assign clr_we = bus_we && hit && (woff == WOFF_CLR);

         intc_bank #(.LINES(LINES_PER_BANK)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .lines  (lvl),
            .set_we (set_we),
            .clr_we (clr_we),
            .wdata  (bus_wdata),
            .mask_o (mask),
            .pend_o (pend)
         );

         assign pend_all[b*LINES_PER_BANK +: LINES_PER_BANK] = pend;
         assign rword[b] = hit ? bank_word(woff, lvl, mask, pend) : '0;
      end
   endgenerate

   logic [WORD_W-1:0] rsel;

   always_comb begin
      rsel = '0;
      for (int b = 0; b < NUM_BANKS; b++) rsel = rsel | rword[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rsel;
      else             bus_rdata <= '0;
   end

   intc_summary #(.SRC_W(SRC_W)) summary_i (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend_all),
      .req_o (irq_out)
   );

   intc_top_enc #(.SRC_W(SRC_W), .IDX_W(IDX_W), .HAS_INDEX(HAS_INDEX)) enc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend_all),
      .valid_o (top_valid),
      .idx_o   (top_idx)
   );

   p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> (bus_rdata == '0));

   p_strobe_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && (woff == WOFF_SET || woff == WOFF_CLR || !aligned)) |=> (bus_rdata == '0));

endmodule

// File: tb/lvl_intc_tb_top.sv
module lvl_intc_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB   = 2;
   localparam int SW   = NB * 32;
   localparam int IW   = $clog2(SW);
   localparam int NVEC = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] irq_src = '0;
   logic [5:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic          bus_re = 1'b0;
   logic [31:0]   bus_rdata;
   logic          irq_out;
   logic          top_valid;
   logic [IW-1:0] top_idx;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvl_intc #(.NUM_BANKS(NB), .ADDR_W(6), .HAS_INDEX(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .bus_rdata(bus_rdata), .irq_out(irq_out), .top_valid(top_valid),
      .top_idx(top_idx)
   );

   // {src bank0, src bank1, clear bank0, clear bank1}
   localparam logic [127:0] VEC [NVEC] = '{
      {32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
      {32'h00000001, 32'h00000000, 32'h00000001, 32'h00000000},
      {32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'h00000000},
      {32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF},
      {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000},
      {32'h0F0F0000, 32'h00000000, 32'hF0F0FFFF, 32'h00000000},
      {32'h12345678, 32'h80000000, 32'h0000FFFF, 32'h80000000},
      {32'hAAAAAAAA, 32'h55555555, 32'h55555555, 32'hAAAAAAAA},
      {32'h00010000, 32'h00000400, 32'h00010000, 32'h00000C00}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   function automatic int top_of(input logic [SW-1:0] p);
      int r = 0;
      for (int i = 0; i < SW; i++) if (p[i]) r = i;
      return r;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [SW-1:0] pe;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq_out", 64'(irq_out), 64'd0);
      check("R1 top_valid", 64'(top_valid), 64'd0);
      bus_read(6'h04, rd); check("R1 mask bank0", 64'(rd), 64'hFFFFFFFF);
      bus_read(6'h24, rd); check("R1 mask bank1", 64'(rd), 64'hFFFFFFFF);
      @(negedge clk);
      check("R11 idle rdata", 64'(bus_rdata), 64'd0);

      // vector table: R5 R6 R7 R10
      for (int v = 0; v < NVEC; v++) begin
         logic [31:0] s0, s1, c0, c1;
         {s0, s1, c0, c1} = VEC[v];
         bus_write(6'h08, 32'hFFFFFFFF);
         bus_write(6'h28, 32'hFFFFFFFF);
         bus_write(6'h0C, c0);
         bus_write(6'h2C, c1);
         irq_src = {s1, s0};
         pe = {s1 & c1, s0 & c0};
         bus_read(6'h10, rd); check("R5 pending bank0", 64'(rd), 64'(pe[31:0]));
         bus_read(6'h30, rd); check("R7 pending bank1", 64'(rd), 64'(pe[63:32]));
         bus_read(6'h00, rd); check("R4 level bank0", 64'(rd), 64'(s0));
         check("R6 irq_out", 64'(irq_out), 64'(|pe));
         check("R10 top_valid", 64'(top_valid), 64'(|pe));
         if (|pe) check("R10 top_idx", 64'(top_idx), 64'(top_of(pe)));
      end

      // R2 R3 partial updates
      irq_src = '0;
      bus_write(6'h08, 32'hFFFFFFFF);
      bus_write(6'h0C, 32'h000000F0);
      bus_read(6'h04, rd); check("R3 clear partial", 64'(rd), 64'hFFFFFF0F);
      bus_write(6'h08, 32'h00000030);
      bus_read(6'h04, rd); check("R2 set partial", 64'(rd), 64'hFFFFFF3F);
      bus_read(6'h08, rd); check("R9 set strobe reads 0", 64'(rd), 64'd0);
      bus_read(6'h0C, rd); check("R9 clr strobe reads 0", 64'(rd), 64'd0);

      // R8 writes to level, mask, pending ignored
      bus_write(6'h04, 32'h00000000);
      bus_write(6'h00, 32'h00000000);
      bus_write(6'h10, 32'h00000000);
      bus_read(6'h04, rd); check("R8 mask unchanged", 64'(rd), 64'hFFFFFF3F);

      // R9 unused offsets and unaligned
      bus_write(6'h14, 32'hFFFFFFFF);
      bus_write(6'h0D, 32'hFFFFFFFF);
      bus_write(6'h1C, 32'hFFFFFFFF);
      bus_read(6'h04, rd); check("R9 mask after stray writes", 64'(rd), 64'hFFFFFF3F);
      bus_read(6'h14, rd); check("R9 offset 0x14 reads 0", 64'(rd), 64'd0);
      bus_read(6'h06, rd); check("R9 unaligned reads 0", 64'(rd), 64'd0);

      // R4 level follows input, no latch
      irq_src[5] = 1'b1;
      bus_read(6'h00, rd); check("R4 level high", 64'(rd), 64'h20);
      irq_src[5] = 1'b0;
      bus_read(6'h00, rd); check("R4 level dropped", 64'(rd), 64'h0);

      // R6 one-edge latency, bank0 bit 7 unmasked (mask 0xFFFFFF3F)
      @(negedge clk);
      irq_src[7] = 1'b1;
      #1 check("R6 not yet asserted", 64'(irq_out), 64'd0);
      @(negedge clk);
      check("R6 asserted after edge", 64'(irq_out), 64'd1);
      check("R10 idx bit7", 64'(top_idx), 64'd7);
      irq_src[7] = 1'b0;
      #1 check("R6 still high before edge", 64'(irq_out), 64'd1);
      @(negedge clk);
      check("R6 deasserted after edge", 64'(irq_out), 64'd0);

      // R7 bank1 source 3 -> index 35
      bus_write(6'h2C, 32'h00000008);
      irq_src[35] = 1'b1;
      @(negedge clk);
      check("R7 global index", 64'(top_idx), 64'd35);
      bus_read(6'h30, rd); check("R7 bank1 pending", 64'(rd), 64'h8);
      bus_read(6'h10, rd); check("R7 bank0 unaffected", 64'(rd), 64'h0);

      // R11 read then idle
      @(negedge clk);
      check("R11 rdata zero after idle", 64'(bus_rdata), 64'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule